// File: doc/BRIEF.md
# Upper Context Store Sequencer

This block carries out a store-upper-context instruction. It takes one 32-bit instruction word and recognises either of two addressing forms. The first is an absolute form, whose 18-bit offset is spread over several instruction fields and expands into a segmented address. The second is a base-register form, which adds a sign-extended 10-bit offset to an address register. From the instruction it forms the effective address of a 16-word save area.

Once the address passes an alignment check and a forbidden-region check, the block copies sixteen words into a private buffer on the accept cycle. These are the context-link word, the status word, address registers 10 to 15 and data registers 8 to 15. It then sends the words one at a time to a word-wide memory write port that uses a valid/ready handshake. A surrounding core uses it as a side engine. The core presents the instruction together with a read view of its register files, watches `busy`, and continues on `done` or on an error flag.

Top module: `ucx_store_seq`

## Requirements
- R1: An instruction with bits[7:0]=0x15 and bits[27:26]=2'b01 is the absolute form. Its offset is off18 = {bits[15:12], bits[25:22], bits[31:28], bits[21:16]} (MSB first). The address is {off18[17:14], 14 zero bits, off18[13:0]}. Bits[11:8] have no effect.
- R2: An instruction with bits[7:0]=0x49 and bits[27:22]=6'h27 is the base form. The base register index is bits[15:12] and off10 = {bits[31:28], bits[21:16]}. The address is A[index] plus the sign-extended off10, added modulo 2^32. Bits[11:8] have no effect.
- R3: Word i (0..15) is presented at address EA+4*i with `wr_valid` high. It advances to word i+1 only on a cycle where `wr_valid` and `wr_ready` are both high. While stalled, address and data hold.
- R4: The word order is context-link, status, A10, A11, D8, D9, D10, D11, A12, A13, A14, A15, D12, D13, D14, D15. All values are the ones present on the accept cycle. Later changes on the register inputs have no effect, and the status word is stored unmodified.
- R5: If EA[5:0] is not zero, `err_align` is high for exactly the one cycle after the accept cycle. No write is made, and the block stays idle.
- R6: If EA[31:28] equals the parameter PERIPH_SEG (default 4'hF), `err_region` is high for exactly the one cycle after the accept cycle, and no write is made. Both flags rise together when both faults apply.
- R7: An instruction matching neither form is ignored: no busy, no write, no error flag.
- R8: `busy` rises in the cycle after a recognised, fault-free instruction and stays high until the last word is accepted. Instructions presented while busy are ignored.
- R9: `done` is high for exactly one cycle, the cycle after the sixteenth handshake. `busy` and `wr_valid` are low in that cycle.
- R10: After reset, `busy`, `done`, `wr_valid`, `err_align` and `err_region` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| a_regs | input | 512 | Address registers A0..A15, A[i] at bits 32*i+31:32*i |
| d_regs | input | 256 | Data registers D8..D15, D[8+j] at bits 32*j+31:32*j |
| psw | input | 32 | Current status word |
| pcxi | input | 32 | Previous context link word |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 32 | Byte address of the beat |
| wr_data | output | 32 | Word written |
| busy | output | 1 | Store sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_align | output | 1 | Address not on a 64-byte boundary |
| err_region | output | 1 | Address in the forbidden segment |

## Verification
The bench builds instructions whose offsets have the sign bit set. A design that mis-ordered the scattered offset fields, or zero-extended off10, would write to the wrong address. One base-form case adds across the 2^32 boundary, and one case trips both faults together. The bench toggles `wr_ready` at random and changes every register input right after the accept cycle, so a design that advanced on valid alone or read registers live would store the wrong words. Instructions presented during a busy sequence would raise a stray error flag or restart the sequence if they were not ignored.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
    localparam int XLEN       = 32;
    localparam int CTX_WORDS  = 16;
    localparam int BEAT_W     = $clog2(CTX_WORDS);
    localparam int NUM_AREG   = 16;
    localparam int NUM_DHI    = 8;
    localparam int A_HI_FIRST = 10;
    localparam int NUM_AHI    = NUM_AREG - A_HI_FIRST;
    localparam int ALIGN_BITS = $clog2(CTX_WORDS * (XLEN / 8));

    localparam logic [7:0] OPC_ABS = 8'h15;
    localparam logic [1:0] SUB_ABS = 2'b01;
    localparam logic [7:0] OPC_BO  = 8'h49;
    localparam logic [5:0] SUB_BO  = 6'h27;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        SRC_LINK,
        SRC_STAT,
        SRC_AREG,
        SRC_DREG
    } src_kind_e;

    typedef struct packed {
        src_kind_e   kind;
        logic [3:0]  idx;   // register number (A or D)
    } slot_src_t;

    typedef enum logic {
        PH_IDLE,
        PH_STORE
    } phase_e;

    // Fixed save-area ordering: slot number -> source register
    function automatic slot_src_t slot_source(input int slot);
        slot_src_t s;
        s.kind = SRC_LINK;
        s.idx  = 4'd0;
        if (slot == 0) begin
            s.kind = SRC_LINK;
        end else if (slot == 1) begin
            s.kind = SRC_STAT;
        end else if (slot < 4) begin
            s.kind = SRC_AREG;
            s.idx  = 4'(slot + 8);
        end else if (slot < 8) begin
            s.kind = SRC_DREG;
            s.idx  = 4'(slot + 4);
        end else if (slot < 12) begin
            s.kind = SRC_AREG;
            s.idx  = 4'(slot + 4);
        end else begin
            s.kind = SRC_DREG;
            s.idx  = 4'(slot);
        end
        return s;
    endfunction
endpackage

// File: rtl/ucx_decode.sv
module ucx_decode
    import ucx_pkg::*;
(
    input  logic [XLEN-1:0]          instr,
    input  logic [NUM_AREG*XLEN-1:0] a_regs,
    output logic                     hit,
    output logic [XLEN-1:0]          ea
);
    logic        is_abs;
    logic        is_bo;
    logic [17:0] off18;
    logic [9:0]  off10;
    logic [3:0]  base_idx;
    word_t       base_val;
    word_t       ea_abs;
    word_t       ea_bo;

    always_comb begin
        is_abs   = (instr[7:0] == OPC_ABS) && (instr[27:26] == SUB_ABS);
        is_bo    = (instr[7:0] == OPC_BO)  && (instr[27:22] == SUB_BO);

        off18    = {instr[15:12], instr[25:22], instr[31:28], instr[21:16]};
        ea_abs   = {off18[17:14], 14'b0, off18[13:0]};

        off10    = {instr[31:28], instr[21:16]};
        base_idx = instr[15:12];
        base_val = a_regs[32'(base_idx) * XLEN +: XLEN];
        ea_bo    = base_val + {{(XLEN-10){off10[9]}}, off10};

        hit      = is_abs || is_bo;
        ea       = is_bo ? ea_bo : ea_abs;
    end
endmodule

// File: rtl/ucx_guard.sv
module ucx_guard
    import ucx_pkg::*;
#(
    parameter int                  SEG_BITS   = 4,
    parameter logic [SEG_BITS-1:0] PERIPH_SEG = '1
) (
    input  logic [XLEN-1:0] ea,
    output logic            bad_align,
    output logic            bad_region
);
    always_comb begin
        bad_align  = |ea[ALIGN_BITS-1:0];
        bad_region = (ea[XLEN-1 -: SEG_BITS] == PERIPH_SEG);
    end
endmodule

// File: rtl/ucx_snapshot.sv
module ucx_snapshot
    import ucx_pkg::*;
(
    input  logic [NUM_AHI*XLEN-1:0]              a_hi,
    input  logic [NUM_DHI*XLEN-1:0]              d_hi,
    input  logic [XLEN-1:0]                      psw,
    input  logic [XLEN-1:0]                      pcxi,
    output logic [CTX_WORDS-1:0][XLEN-1:0]       ctx
);
    for (genvar g = 0; g < CTX_WORDS; g++) begin : g_slot
        localparam slot_src_t SRC = slot_source(g);
        if (SRC.kind == SRC_LINK) begin : g_link
            assign ctx[g] = pcxi;
        end else if (SRC.kind == SRC_STAT) begin : g_stat
            assign ctx[g] = psw;
        end else if (SRC.kind == SRC_AREG) begin : g_areg
            assign ctx[g] = a_hi[(int'(SRC.idx) - A_HI_FIRST)*XLEN +: XLEN];
        end else begin : g_dreg
            assign ctx[g] = d_hi[(int'(SRC.idx) - 8)*XLEN +: XLEN];
        end
    end
endmodule

// File: rtl/ucx_store_seq.sv
module ucx_store_seq
    import ucx_pkg::*;
#(
    parameter int                  SEG_BITS   = 4,
    parameter logic [SEG_BITS-1:0] PERIPH_SEG = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     instr_valid,
    input  logic [XLEN-1:0]          instr,
    input  logic [NUM_AREG*XLEN-1:0] a_regs,
    input  logic [NUM_DHI*XLEN-1:0]  d_regs,
    input  logic [XLEN-1:0]          psw,
    input  logic [XLEN-1:0]          pcxi,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [XLEN-1:0]          wr_addr,
    output logic [XLEN-1:0]          wr_data,
    output logic                     busy,
    output logic                     done,
    output logic                     err_align,
    output logic                     err_region
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(CTX_WORDS - 1);

    typedef struct packed {
        phase_e                          phase;
        logic [BEAT_W-1:0]               beat;
        word_t                           base;
        logic [CTX_WORDS-1:0][XLEN-1:0]  ctx;
        logic                            done;
        logic                            err_align;
        logic                            err_region;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic                            dec_hit;
    word_t                           dec_ea;
    logic                            bad_align;
    logic                            bad_region;
    logic [CTX_WORDS-1:0][XLEN-1:0]  snap;

    ucx_decode u_decode (
        .instr  (instr),
        .a_regs (a_regs),
        .hit    (dec_hit),
        .ea     (dec_ea)
    );

    ucx_guard #(
        .SEG_BITS   (SEG_BITS),
        .PERIPH_SEG (PERIPH_SEG)
    ) u_guard (
        .ea         (dec_ea),
        .bad_align  (bad_align),
        .bad_region (bad_region)
    );

    ucx_snapshot u_snap (
        .a_hi (a_regs[NUM_AREG*XLEN-1 : A_HI_FIRST*XLEN]),
        .d_hi (d_regs),
        .psw  (psw),
        .pcxi (pcxi),
        .ctx  (snap)
    );

    always_comb begin
        st_d            = st_q;
        st_d.done       = 1'b0;
        st_d.err_align  = 1'b0;
        st_d.err_region = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (instr_valid && dec_hit) begin
                    if (bad_align || bad_region) begin
                        st_d.err_align  = bad_align;
                        st_d.err_region = bad_region;
                    end else begin
                        st_d.phase = PH_STORE;
                        st_d.beat  = '0;
                        st_d.base  = dec_ea;
                        st_d.ctx   = snap;
                    end
                end
            end
            PH_STORE: begin
                if (wr_ready) begin
                    if (st_q.beat == LAST_BEAT) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.beat = st_q.beat + 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.phase == PH_STORE);
    assign wr_valid   = busy;
    assign wr_addr    = st_q.base + {{(XLEN-BEAT_W-2){1'b0}}, st_q.beat, 2'b00};
    assign wr_data    = st_q.ctx[st_q.beat];
    assign done       = st_q.done;
    assign err_align  = st_q.err_align;
    assign err_region = st_q.err_region;
endmodule

// File: rtl/ucx_store_seq_chk.sv
module ucx_store_seq_chk #(
    parameter int                  SEG_BITS   = 4,
    parameter logic [SEG_BITS-1:0] PERIPH_SEG = '1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        err_align,
    input logic        err_region,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data
);
    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_addr[5:2] != 4'hF) |=> wr_valid && (wr_addr == $past(wr_addr) + 32'd4));

    // R5
    first_beat_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> (wr_addr[5:0] == 6'd0));

    // R6
    no_periph_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[31 -: SEG_BITS] != PERIPH_SEG));

    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_region) |-> !busy && !wr_valid && !done);

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_region) |=> !err_align && !err_region);

    // R9
    last_beat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_addr[5:2] == 4'hF) |=> done && !busy && !wr_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !err_align && !err_region);
endmodule

bind ucx_store_seq ucx_store_seq_chk #(
    .SEG_BITS   (SEG_BITS),
    .PERIPH_SEG (PERIPH_SEG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err_align  (err_align),
    .err_region (err_region),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
);

// File: tb/ucx_store_seq_test.sv
module ucx_store_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic [511:0] a_flat;
    logic [255:0] d_flat;
    logic [31:0] psw, pcxi;
    logic        wr_valid, wr_ready;
    logic [31:0] wr_addr, wr_data;
    logic        busy, done, err_align, err_region;

    logic [31:0] a_rf [16];
    logic [31:0] d_rf [8];   // D8..D15
    logic [31:0] sa [16];
    logic [31:0] sd [8];
    logic [31:0] s_psw, s_pcxi;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) a_flat[i*32 +: 32] = a_rf[i];
        for (int j = 0; j < 8; j++)  d_flat[j*32 +: 32] = d_rf[j];
    end

    ucx_store_seq uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .a_regs(a_flat), .d_regs(d_flat), .psw(psw), .pcxi(pcxi),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .err_align(err_align), .err_region(err_region)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_abs(input logic [17:0] o, input logic [3:0] spare);
        logic [31:0] w = 32'd0;
        w[7:0] = 8'h15; w[27:26] = 2'b01; w[11:8] = spare;
        w[15:12] = o[17:14]; w[25:22] = o[13:10]; w[31:28] = o[9:6]; w[21:16] = o[5:0];
        return w;
    endfunction

    function automatic logic [31:0] enc_bo(input logic [3:0] b, input logic [9:0] o, input logic [3:0] spare);
        logic [31:0] w = 32'd0;
        w[7:0] = 8'h49; w[27:22] = 6'h27; w[11:8] = spare;
        w[15:12] = b; w[21:16] = o[5:0]; w[31:28] = o[9:6];
        return w;
    endfunction

    function automatic logic [31:0] ea_abs(input logic [17:0] o);
        return {o[17:14], 14'd0, o[13:0]};
    endfunction

    function automatic logic [31:0] sext10(input logic [9:0] o);
        return {{22{o[9]}}, o};
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        if (k == 0) return s_pcxi;
        if (k == 1) return s_psw;
        if (k < 4)  return sa[k + 8];
        if (k < 8)  return sd[k - 4];
        if (k < 12) return sa[k + 4];
        return sd[k - 8];
    endfunction

    task automatic scramble_regs();
        for (int i = 0; i < 16; i++) a_rf[i] = $urandom;
        for (int j = 0; j < 8; j++)  d_rf[j] = $urandom;
        psw  = $urandom;
        pcxi = $urandom;
    endtask

    // Present one instruction at a negedge and follow it to completion.
    task automatic issue(input logic [31:0] ins, input bit recog, input logic [31:0] ea, input bit stall_mix);
        bit   ex_al, ex_rg;
        int   beat;
        int   guard;
        ex_al = (ea[5:0] != 6'd0);
        ex_rg = (ea[31:28] == 4'hF);
        for (int i = 0; i < 16; i++) sa[i] = a_rf[i];
        for (int j = 0; j < 8; j++)  sd[j] = d_rf[j];
        s_psw = psw; s_pcxi = pcxi;
        instr_valid = 1'b1;
        instr = ins;
        @(negedge clk);
        instr_valid = 1'b0;
        scramble_regs();   // R4: must not reach the stored words
        if (!recog) begin
            chk(!busy && !wr_valid, "R7 unrecognised busy/valid", {busy, wr_valid}, 0);
            chk(!err_align && !err_region, "R7 unrecognised errors", {err_align, err_region}, 0);
            @(negedge clk);
            chk(!busy && !wr_valid && !done, "R7 still idle", {busy, wr_valid, done}, 0);
            return;
        end
        if (ex_al || ex_rg) begin
            chk(err_align == ex_al, "R5 align flag", err_align, ex_al);
            chk(err_region == ex_rg, "R6 region flag", err_region, ex_rg);
            chk(!busy && !wr_valid, "R5 R6 no writes", {busy, wr_valid}, 0);
            @(negedge clk);
            chk(!err_align && !err_region, "R5 R6 flags one cycle", {err_align, err_region}, 0);
            chk(!busy && !wr_valid, "R5 R6 idle after", {busy, wr_valid}, 0);
            return;
        end
        chk(busy == 1'b1, "R8 busy after accept", busy, 1);
        beat  = 0;
        guard = 0;
        while (beat < 16 && guard < 400) begin
            wr_ready = stall_mix ? (($urandom % 3) != 0) : 1'b1;
            instr_valid = (($urandom % 4) == 0);       // R8: ignored while busy
            instr = enc_abs({4'h3, 8'h00, 6'h05}, 4'h0);   // misaligned if ever taken
            chk(wr_valid && busy, "R8 valid while storing", {wr_valid, busy}, 2'b11);
            chk(wr_addr == ea + 32'(beat * 4), "R1 R2 R3 beat address", wr_addr, ea + 32'(beat * 4));
            chk(wr_data == exp_word(beat), "R4 beat data", wr_data, exp_word(beat));
            chk(!err_align && !err_region && !done, "R8 no flags while busy", {err_align, err_region, done}, 0);
            if (wr_ready) beat++;
            guard++;
            @(negedge clk);
        end
        instr_valid = 1'b0;
        wr_ready = 1'b0;
        chk(beat == 16, "R3 all beats taken", beat, 16);
        chk(done && !busy && !wr_valid, "R9 done after last beat", {done, busy, wr_valid}, 3'b100);
        @(negedge clk);
        chk(!done && !busy, "R9 done one cycle", {done, busy}, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5EED_0042);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        instr = 32'd0;
        wr_ready = 1'b0;
        scramble_regs();
        repeat (3) @(negedge clk);
        chk({busy, done, wr_valid, err_align, err_region} == 5'd0, "R10 reset outputs",
            {busy, done, wr_valid, err_align, err_region}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, wr_valid, err_align, err_region} == 5'd0, "R10 after release",
            {busy, done, wr_valid, err_align, err_region}, 0);

        // R1: directed absolute, offset fields all distinct, spare bits set
        issue(enc_abs({4'h7, 4'hA, 4'h5, 6'h00}, 4'hF), 1'b1, ea_abs({4'h7, 4'hA, 4'h5, 6'h00}), 1'b0);
        // R1: high offset bits all ones, segment 0xE
        issue(enc_abs({4'hE, 8'hFF, 6'h00}, 4'h0), 1'b1, ea_abs({4'hE, 8'hFF, 6'h00}), 1'b1);
        // R2: negative offset lands exactly on zero
        a_rf[3] = 32'h0000_0010;
        issue(enc_bo(4'd3, 10'h3F0, 4'h9), 1'b1, 32'h0000_0000, 1'b1);
        // R2: addition wraps across 2^32
        a_rf[12] = 32'hFFFF_FFF0;
        issue(enc_bo(4'd12, 10'h050, 4'h0), 1'b1, 32'h0000_0040, 1'b1);
        // R5: misaligned base form
        a_rf[1] = 32'h1000_0000;
        issue(enc_bo(4'd1, 10'h004, 4'h0), 1'b1, 32'h1000_0004, 1'b0);
        // R6: forbidden segment, aligned
        issue(enc_abs({4'hF, 8'h00, 6'h00}, 4'h0), 1'b1, ea_abs({4'hF, 8'h00, 6'h00}), 1'b0);
        // R5 R6: both faults at once
        issue(enc_abs({4'hF, 8'h01, 6'h21}, 4'h0), 1'b1, ea_abs({4'hF, 8'h01, 6'h21}), 1'b0);
        // R7: wrong secondary opcode for each form
        issue(32'h0800_0015, 1'b0, 32'd0, 1'b0);
        issue(32'h09C0_0049 ^ 32'h0040_0000, 1'b0, 32'd0, 1'b0);

        // Random mix of both forms
        for (int t = 0; t < 40; t++) begin
            logic [31:0] ins, ea, target;
            logic [17:0] o18;
            logic [9:0]  o10;
            logic [3:0]  b;
            bit          mis;
            mis = (($urandom % 5) == 0);
            if ($urandom % 2) begin
                o18 = 18'($urandom);
                if (!mis) o18[5:0] = 6'd0;
                ins = enc_abs(o18, 4'($urandom));
                ea  = ea_abs(o18);
            end else begin
                b      = 4'($urandom);
                o10    = 10'($urandom);
                target = {$urandom} & 32'hFFFF_FFC0;
                if (mis) target[5:0] = 6'($urandom) | 6'd1;
                a_rf[b] = target - sext10(o10);
                ins = enc_bo(b, o10, 4'($urandom));
                ea  = target;
            end
            issue(ins, 1'b1, ea, 1'b1);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule